// File: doc/BRIEF.md
# Synchronous SRAM Cycle Controller with Byte-Lane Writes

This block is the clocked control front end of a flow-through synchronous burst SRAM. At every rising clock edge it looks at three chip enables, two address strobes (one on the processor side, one on the controller side) and the write controls: a global write, a byte-write enable and one enable per byte lane. From these it classifies the cycle as deselect, read or write. It works out which byte lanes are written, and it tracks which of five cycle states the memory is in. Each lane is nine bits wide: eight data bits and a parity bit.

A small storage bank per lane is included so that the data path can be checked end to end. Read data comes straight from the array at the registered address, with no output register, so it is valid in the same cycle that registers the address. The output drivers are enabled only in read states and only while the asynchronous output enable is low. Burst address sequencing and sleep handling belong to separate blocks. A cycle with no strobe reuses the registered address.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: On a controller-strobe cycle that starts with all enables valid and `all_wr_n` low, every lane is written. The byte-write enable and the lane selects have no effect. `lane_wstrb` then shows all ones.
- R2: With `all_wr_n` high and `lane_wr_en_n` low, exactly the lanes whose `lane_sel_n` bit is 0 are written. Bit k of `lane_wstrb` is the inverse of `lane_sel_n[k]`, for any combination of lanes.
- R3: A cycle is a read, with `lane_wstrb` all zero, when both `all_wr_n` and `lane_wr_en_n` are high. It is also a read when `lane_wr_en_n` is low but every `lane_sel_n` bit is 1.
- R4: A controller-strobe cycle starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination deselects: the state goes to 0, nothing is written and no lane drives. When `ce1_n`=1 on a processor-strobe cycle, the cycle deselects as well.
- R5: A processor-strobe cycle checks only `ce1_n`. It ignores `ce2` and `ce3_n`, always starts a read and writes nothing. When both strobes are low, the processor strobe takes priority.
- R6: `cycle_state` encodes 0 for deselected, 1 for first read, 2 for first write, 3 for burst read and 4 for burst write. A valid start goes to state 1 or 2. A cycle with no strobe goes from any non-zero state to 3 or 4, chosen by the write decode of that cycle. A cycle with no strobe keeps state 0 in state 0 and writes nothing.
- R7: Read data is flow-through. `rdata` carries the word at the registered address in the cycle after the edge that registered it.
- R8: `dq_oe` is all ones exactly while the state is 1 or 3 and `oe_n` is low. Otherwise it is all zeros. A change on `oe_n` takes effect without waiting for a clock.
- R9: After reset the state is 0, `lane_wstrb` is zero and `dq_oe` is zero.
- R10: A cycle with no strobe reads and writes the address registered by the last start. It ignores `addr`.
- R11: Lane k occupies bits [9k+8:9k] of `wdata` and `rdata`. Bit 9k+8 is that lane's parity bit, and it is stored like the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Primary chip enable, active low, checked with either strobe |
| ce2 | input | 1 | Secondary chip enable, active high, checked with controller strobe only |
| ce3_n | input | 1 | Secondary chip enable, active low, checked with controller strobe only |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address, registered on a start |
| wdata | input | LANES*9 | Write data, nine bits per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Flow-through read data |
| dq_oe | output | LANES | Per-lane output driver enable |
| lane_wstrb | output | LANES | Lanes written at the most recent edge |
| cycle_state | output | 3 | Current cycle state (encoding in R6) |

## Verification
Errors in the registered state show up as soon as one clock later. A wrong cycle state or a wrong lane mask appears at `cycle_state`, `dq_oe` or `lane_wstrb` in the cycle right after the edge that sampled the command. Lost or misplaced writes stay hidden until the word is read back. For that reason each write scenario ends with a read of the same address, which compares every lane of `rdata` against a shadow copy. Deselect and ignored-control cases are checked by reading back the words they could have corrupted.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_FIRST = 3'd1,
    ST_WR_FIRST = 3'd2,
    ST_RD_BURST = 3'd3,
    ST_WR_BURST = 3'd4
  } cyc_state_e;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_START = 2'd1,
    CMD_CONT  = 2'd2
  } cyc_cmd_e;

  localparam int unsigned LANE_BITS = 9;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cyc_cmd_e         cmd,
  output logic [LANES-1:0] lane_mask
);

  logic [LANES-1:0] req_mask;
  logic             cpu_go;
  logic             ctl_go;
  logic             ctl_enabled;

  // Global write wins over the byte controls; otherwise byte lanes
  // follow their selects only when the byte-write enable is active.
  always_comb begin
    if (!all_wr_n) begin
      req_mask = '1;
    end else if (!lane_wr_en_n) begin
      req_mask = ~lane_sel_n;
    end else begin
      req_mask = '0;
    end
  end

  assign cpu_go      = ~cpu_strobe_n;
  assign ctl_go      = ~ctl_strobe_n & cpu_strobe_n;
  assign ctl_enabled = ~ce1_n & ce2 & ~ce3_n;

  always_comb begin
    cmd       = CMD_CONT;
    lane_mask = req_mask;
    if (cpu_go) begin
      lane_mask = '0;
      cmd       = ce1_n ? CMD_DESEL : CMD_START;
    end else if (ctl_go) begin
      if (ctl_enabled) begin
        cmd = CMD_START;
      end else begin
        cmd       = CMD_DESEL;
        lane_mask = '0;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_cmd_e          cmd,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [ADDR_W-1:0] addr_in,
  output cyc_state_e        state_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  wstrb_q,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_waddr
);

  cyc_state_e        state_d;
  logic [LANES-1:0]  wstrb_d;
  logic              addr_load;
  logic              wr_cycle;
  logic              write_ok;

  assign wr_cycle  = |lane_mask;
  assign addr_load = (cmd == CMD_START);
  assign write_ok  = (cmd == CMD_START) ||
                     ((cmd == CMD_CONT) && (state_q != ST_IDLE));

  always_comb begin
    state_d = state_q;
    unique case (cmd)
      CMD_DESEL: state_d = ST_IDLE;
      CMD_START: state_d = wr_cycle ? ST_WR_FIRST : ST_RD_FIRST;
      CMD_CONT: begin
        if (state_q != ST_IDLE) begin
          state_d = wr_cycle ? ST_WR_BURST : ST_RD_BURST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign wstrb_d   = write_ok ? lane_mask : '0;
  assign mem_we    = wstrb_d;
  assign mem_waddr = addr_load ? addr_in : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wstrb_q <= '0;
    end else begin
      state_q <= state_d;
      wstrb_q <= wstrb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_load) begin
      addr_q <= addr_in;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd == CMD_CONT) |=> (state_q == ST_IDLE && wstrb_q == '0)); // R6
  AST_CONT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CONT) |=> $stable(addr_q)); // R10
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_IDLE, ST_RD_FIRST, ST_WR_FIRST, ST_RD_BURST, ST_WR_BURST})); // R6

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LANE_W = LANE_BITS,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  dq_oe,
  output logic [LANES-1:0]  lane_wstrb,
  output logic [2:0]        cycle_state
);

  cyc_cmd_e          cmd;
  logic [LANES-1:0]  lane_mask;
  cyc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic              rd_state;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .ce1_n        (ce1_n),
    .ce2          (ce2),
    .ce3_n        (ce3_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .cmd          (cmd),
    .lane_mask    (lane_mask)
  );

  sram_cycle_fsm #(.LANES(LANES), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .lane_mask (lane_mask),
    .addr_in   (addr),
    .state_q   (state_q),
    .addr_q    (addr_q),
    .wstrb_q   (lane_wstrb),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .we    (mem_we[k]),
      .waddr (mem_waddr),
      .wdata (wdata[k*LANE_W +: LANE_W]),
      .raddr (addr_q),
      .rdata (rdata[k*LANE_W +: LANE_W])
    );
  end

  // Drivers follow the registered cycle type, gated by the async enable.
  assign rd_state    = (state_q == ST_RD_FIRST) || (state_q == ST_RD_BURST);
  assign dq_oe       = {LANES{rd_state & ~oe_n}};
  assign cycle_state = state_q;

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && cpu_strobe_n && !ce1_n && ce2 && !ce3_n && !all_wr_n)
      |=> (lane_wstrb == {LANES{1'b1}})); // R1
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && cpu_strobe_n && !ce1_n && ce2 && !ce3_n && all_wr_n && !lane_wr_en_n)
      |=> (lane_wstrb == ~$past(lane_sel_n))); // R2
  AST_SECONDARY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && cpu_strobe_n && (!ce2 || ce3_n))
      |=> (cycle_state == 3'd0 && lane_wstrb == '0)); // R4
  AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !ce1_n) |=> (cycle_state == 3'd1 && lane_wstrb == '0)); // R5
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wstrb != '0) |-> (dq_oe == '0)); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dq_oe == '0)); // R8

endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;

  localparam int unsigned LN = 4;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = LN * 9;

  logic          clk;
  logic          rst_n;
  logic          ce1_n, ce2, ce3_n;
  logic          cpu_strobe_n, ctl_strobe_n;
  logic          all_wr_n, lane_wr_en_n;
  logic [LN-1:0] lane_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          oe_n;
  logic [DW-1:0] rdata;
  logic [LN-1:0] dq_oe;
  logic [LN-1:0] lane_wstrb;
  logic [2:0]    cycle_state;

  int checks;
  int fails;
  bit done;
  logic [DW-1:0] shadow [1 << AW];

  sram_cycle_ctrl #(.LANES(LN), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .dq_oe(dq_oe),
    .lane_wstrb(lane_wstrb), .cycle_state(cycle_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one command at the falling edge, let it be sampled, then settle.
  task automatic run_cycle(input logic c_cpu, input logic c_ctl, input logic c_e1,
                           input logic c_e2, input logic c_e3, input logic c_gw,
                           input logic c_bw, input logic [LN-1:0] c_sel,
                           input logic [AW-1:0] c_a, input logic [DW-1:0] c_d);
    @(negedge clk);
    cpu_strobe_n = c_cpu; ctl_strobe_n = c_ctl;
    ce1_n = c_e1; ce2 = c_e2; ce3_n = c_e3;
    all_wr_n = c_gw; lane_wr_en_n = c_bw; lane_sel_n = c_sel;
    addr = c_a; wdata = c_d;
    @(posedge clk);
    #5;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a);
    run_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, a, '0);
  endtask

  task automatic deselect();
    run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '1, '0, '0);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] m);
    logic [DW-1:0] r;
    r = old_w;
    for (int k = 0; k < LN; k++) if (m[k]) r[k*9 +: 9] = new_w[k*9 +: 9];
    return r;
  endfunction

  task automatic t_reset();
    chk("R9 state", DW'(cycle_state), DW'(0));
    chk("R9 wstrb", DW'(lane_wstrb), DW'(0));
    chk("R9 dq_oe", DW'(dq_oe), DW'(0));
  endtask

  task automatic t_global_write();
    run_cycle(1, 0, 0, 1, 0, 0, 1, 4'hF, 4'd3, 36'h1_2345_6789);
    shadow[3] = 36'h1_2345_6789;
    chk("R1 wstrb gw", DW'(lane_wstrb), DW'(4'hF));
    chk("R6 first write", DW'(cycle_state), DW'(2));
    chk("R8 no drive on write", DW'(dq_oe), DW'(0));
    run_cycle(1, 0, 0, 1, 0, 0, 0, 4'b0101, 4'd4, 36'hF_EDCB_A987);
    shadow[4] = 36'hF_EDCB_A987;
    chk("R1 gw overrides byte ctl", DW'(lane_wstrb), DW'(4'hF));
    cpu_read(4'd3);
    chk("R7 flow-through read", rdata, shadow[3]);
    chk("R8 drive on read", DW'(dq_oe), DW'(4'hF));
    cpu_read(4'd4);
    chk("R11 all lanes incl parity", rdata, shadow[4]);
  endtask

  task automatic t_byte_write();
    run_cycle(1, 0, 0, 1, 0, 1, 0, 4'b1010, 4'd3, 36'hA_AAAA_AAAA);
    shadow[3] = merge(shadow[3], 36'hA_AAAA_AAAA, 4'b0101);
    chk("R2 lanes 0,2", DW'(lane_wstrb), DW'(4'b0101));
    cpu_read(4'd3);
    chk("R2 merged word", rdata, shadow[3]);
    run_cycle(1, 0, 0, 1, 0, 1, 0, 4'b0110, 4'd3, 36'h5_5555_5555);
    shadow[3] = merge(shadow[3], 36'h5_5555_5555, 4'b1001);
    chk("R2 lanes 0,3", DW'(lane_wstrb), DW'(4'b1001));
    cpu_read(4'd3);
    chk("R11 lane placement", rdata, shadow[3]);
  endtask

  task automatic t_read_forms();
    run_cycle(1, 0, 0, 1, 0, 1, 0, 4'hF, 4'd4, 36'h0_0000_0001);
    chk("R3 bw low no lanes state", DW'(cycle_state), DW'(1));
    chk("R3 bw low no lanes wstrb", DW'(lane_wstrb), DW'(0));
    chk("R3 data unchanged", rdata, shadow[4]);
    run_cycle(1, 0, 0, 1, 0, 1, 1, 4'h0, 4'd3, 36'h0_0000_0002);
    chk("R3 bw high read", DW'(cycle_state), DW'(1));
    chk("R3 bw high data", rdata, shadow[3]);
  endtask

  task automatic t_enables();
    run_cycle(1, 0, 0, 0, 0, 0, 1, 4'hF, 4'd4, 36'h0_DEAD_0000);
    chk("R4 ce2 low desel", DW'(cycle_state), DW'(0));
    chk("R4 ce2 low no write", DW'(lane_wstrb), DW'(0));
    chk("R4 desel no drive", DW'(dq_oe), DW'(0));
    run_cycle(1, 0, 0, 1, 1, 0, 1, 4'hF, 4'd4, 36'h0_DEAD_0001);
    chk("R4 ce3 high desel", DW'(cycle_state), DW'(0));
    run_cycle(1, 0, 1, 1, 0, 0, 1, 4'hF, 4'd4, 36'h0_DEAD_0002);
    chk("R4 ce1 high ctl desel", DW'(cycle_state), DW'(0));
    run_cycle(0, 1, 1, 1, 0, 1, 1, 4'hF, 4'd4, '0);
    chk("R4 ce1 high cpu desel", DW'(cycle_state), DW'(0));
    cpu_read(4'd4);
    chk("R4 word untouched", rdata, shadow[4]);
  endtask

  task automatic t_cpu_strobe();
    run_cycle(0, 1, 0, 0, 1, 0, 0, 4'h0, 4'd3, 36'h0_BAD0_BAD0);
    chk("R5 secondary ignored", DW'(cycle_state), DW'(1));
    chk("R5 write ctl ignored", DW'(lane_wstrb), DW'(0));
    chk("R5 data kept", rdata, shadow[3]);
    run_cycle(0, 0, 0, 1, 0, 0, 1, 4'hF, 4'd4, 36'h0_BAD1_BAD1);
    chk("R5 cpu priority state", DW'(cycle_state), DW'(1));
    chk("R5 cpu priority data", rdata, shadow[4]);
  endtask

  task automatic t_burst();
    run_cycle(1, 0, 0, 1, 0, 0, 1, 4'hF, 4'd6, 36'h3_1111_2222);
    shadow[6] = 36'h3_1111_2222;
    chk("R6 start write", DW'(cycle_state), DW'(2));
    run_cycle(1, 1, 0, 1, 0, 0, 1, 4'hF, 4'd0, 36'h4_3333_4444);
    shadow[6] = 36'h4_3333_4444;
    chk("R6 burst write", DW'(cycle_state), DW'(4));
    chk("R6 burst write lanes", DW'(lane_wstrb), DW'(4'hF));
    run_cycle(1, 1, 0, 1, 0, 1, 1, 4'hF, 4'd9, '0);
    chk("R6 burst read", DW'(cycle_state), DW'(3));
    chk("R10 same address", rdata, shadow[6]);
    run_cycle(1, 1, 0, 1, 0, 1, 0, 4'b1110, 4'd2, 36'h1_FFFF_FFFF);
    shadow[6] = merge(shadow[6], 36'h1_FFFF_FFFF, 4'b0001);
    chk("R2 burst byte lane", DW'(lane_wstrb), DW'(4'b0001));
    run_cycle(1, 1, 0, 1, 0, 1, 1, 4'hF, 4'd2, '0);
    chk("R10 merged burst word", rdata, shadow[6]);
    deselect();
    chk("R6 deselect", DW'(cycle_state), DW'(0));
    run_cycle(1, 1, 0, 1, 0, 0, 1, 4'hF, 4'd6, 36'h0_0BAD_0BAD);
    chk("R6 idle stays idle", DW'(cycle_state), DW'(0));
    chk("R6 idle no write", DW'(lane_wstrb), DW'(0));
    cpu_read(4'd6);
    chk("R6 idle kept word", rdata, shadow[6]);
  endtask

  task automatic t_oe();
    cpu_read(4'd3);
    oe_n = 1'b1;
    #1;
    chk("R8 oe high async off", DW'(dq_oe), DW'(0));
    oe_n = 1'b0;
    #1;
    chk("R8 oe low async on", DW'(dq_oe), DW'(4'hF));
    run_cycle(1, 1, 0, 1, 0, 1, 1, 4'hF, 4'd0, '0);
    chk("R8 burst read drives", DW'(dq_oe), DW'(4'hF));
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; all_wr_n = 1'b1;
    lane_wr_en_n = 1'b1; lane_sel_n = '1; addr = '0; wdata = '0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_global_write();
    t_byte_write();
    t_read_forms();
    t_enables();
    t_cpu_strobe();
    t_burst();
    t_oe();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule